// File: doc/BRIEF.md
# Oscillator Frequency Meter with Count Limits

This block measures how fast an on-chip oscillating signal runs. The signal can be a clock multiplier output, or a delay chain closed into a ring so that the oscillation period gives the chain delay. A start strobe opens a gate for a programmed number of reference-clock cycles. A counter clocked by the signal under test counts its rising edges while the gate is open. When the gate has closed and the counter has stopped, the final count comes back to the reference domain. There it is compared with a lower and an upper limit.

The count word and the individual limit bits remain visible after the measurement. A tester that only handles single bits can therefore read pass or fail. Characterisation runs can read the full count. Setting both limits to the same value turns the range check into an exact match. A long window lets the count accumulate more edges, which averages out random noise. Choosing a window that spans a whole number of periods of a known interferer makes that periodic disturbance integrate out. If the oscillator is dead, a drain timeout still ends the measurement, with a count of zero.

Top module: `osc_freq_meter`

## Requirements
- R1: After a start, the reported count equals the number of rising edges of `sig_in` during a gate lasting `win_len` reference cycles. It lies within 2 of `win_len * f_sig / f_ref`.
- R2: At capture, `at_least_lo` is set when count >= `lim_lo` and `at_most_hi` is set when count <= `lim_hi`, both compared as unsigned numbers. `pass` is set only when both bits are set and `overflow` is clear.
- R3: With `lim_lo` equal to `lim_hi`, `pass` is set only when the count equals that value exactly.
- R4: `done` is high for exactly one reference cycle, in the same cycle that the new count and flags first appear. These outputs then hold until the next accepted start.
- R5: A start accepted while idle clears `count`, `overflow`, `at_least_lo`, `at_most_hi` and `pass` on the next reference cycle. A start given while a measurement is in progress is ignored, and that measurement completes with its original window.
- R6: If the count would pass all ones, it stays at all ones and `overflow` is set. When `overflow` is set, `pass` is 0 whatever the limits.
- R7: If `sig_in` does not toggle, or `win_len` is 0, `done` still rises no later than `win_len + DRAIN_MAX + 4` reference cycles after the start, and the count is 0.
- R8: Windows of thousands of reference cycles are supported, and the count scales linearly with window length (R1 tolerance).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; times the gate and holds all results |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| sig_in | input | 1 | Oscillating signal under test, used as the counter clock |
| start | input | 1 | Begins a measurement when the block is idle |
| win_len | input | WW | Gate length in reference cycles |
| lim_lo | input | CW | Lower count limit (inclusive) |
| lim_hi | input | CW | Upper count limit (inclusive) |
| count | output | CW | Final edge count of the last measurement |
| done | output | 1 | One-cycle pulse when results are valid |
| at_least_lo | output | 1 | Count is at or above the lower limit |
| at_most_hi | output | 1 | Count is at or below the upper limit |
| pass | output | 1 | Both limit bits are set and no overflow occurred |
| overflow | output | 1 | The counter saturated during the window |

## Verification
Most faults in the gate timer or the synchronizers show up in the count on the next `done`. An off-by-one window length or a missed gate edge moves the count outside the R1 tolerance. A broken return path makes `done` late by the full drain timeout, or makes it report a stale count. Faults in the saturation or comparison logic are visible in the same cycle as `done`. Such a fault shows as a flag that disagrees with the reported count and the limits. A start handler that fails to clear or fails to ignore a start is seen within one cycle, or at the following `done`.

// File: rtl/osc_freq_meter.sv
module osc_freq_meter #(
  parameter int CW        = 16,
  parameter int WW        = 16,
  parameter int DRAIN_MAX = 64
) (
  input  logic          clk_ref,
  input  logic          rst_n,
  input  logic          sig_in,
  input  logic          start,
  input  logic [WW-1:0] win_len,
  input  logic [CW-1:0] lim_lo,
  input  logic [CW-1:0] lim_hi,
  output logic [CW-1:0] count,
  output logic          done,
  output logic          at_least_lo,
  output logic          at_most_hi,
  output logic          pass,
  output logic          overflow
);

  localparam int TW = $clog2(DRAIN_MAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN} st_t;

  st_t           st;
  logic          gate;
  logic [WW-1:0] wcnt;
  logic [TW-1:0] tmo;
  logic          seen;
  logic          a1, a2;

  logic          g1, g2, g3;
  logic [CW-1:0] t_cnt;
  logic          t_ovf;

  // counter domain: gate enters through two flops, third flop finds its rise
  always_ff @(posedge sig_in or negedge rst_n) begin
    if (!rst_n) begin
      g1    <= 1'b0;
      g2    <= 1'b0;
      g3    <= 1'b0;
      t_cnt <= '0;
      t_ovf <= 1'b0;
    end else begin
      g1 <= gate;
      g2 <= g1;
      g3 <= g2;
      if (g2 && !g3) begin
        t_cnt <= CW'(1);
        t_ovf <= 1'b0;
      end else if (g2) begin
        if (&t_cnt) t_ovf <= 1'b1;
        else        t_cnt <= t_cnt + 1'b1;
      end
    end
  end

  // reference domain: synchronized copy of the counter-side gate
  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      a1 <= 1'b0;
      a2 <= 1'b0;
    end else begin
      a1 <= g2;
      a2 <= a1;
    end
  end

  logic          cap_live, cap_tmo, cap;
  logic [CW-1:0] cap_val;
  logic          cap_ovf;

  assign cap_live = (st == S_DRAIN) && seen && !a2;
  assign cap_tmo  = (st == S_DRAIN) && !cap_live && (tmo == TW'(DRAIN_MAX - 1));
  assign cap      = cap_live || cap_tmo;
  assign cap_val  = cap_live ? t_cnt : '0;
  assign cap_ovf  = cap_live && t_ovf;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      gate        <= 1'b0;
      wcnt        <= '0;
      tmo         <= '0;
      seen        <= 1'b0;
      count       <= '0;
      done        <= 1'b0;
      at_least_lo <= 1'b0;
      at_most_hi  <= 1'b0;
      pass        <= 1'b0;
      overflow    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st          <= S_RUN;
          gate        <= (win_len != '0);
          wcnt        <= win_len;
          tmo         <= '0;
          seen        <= 1'b0;
          count       <= '0;
          at_least_lo <= 1'b0;
          at_most_hi  <= 1'b0;
          pass        <= 1'b0;
          overflow    <= 1'b0;
        end
        S_RUN: begin
          if (a2) seen <= 1'b1;
          if (wcnt <= WW'(1)) begin
            gate <= 1'b0;
            st   <= S_DRAIN;
          end else begin
            wcnt <= wcnt - 1'b1;
          end
        end
        S_DRAIN: begin
          if (a2) seen <= 1'b1;
          tmo <= tmo + 1'b1;
          if (cap) begin
            st          <= S_IDLE;
            done        <= 1'b1;
            count       <= cap_val;
            overflow    <= cap_ovf;
            at_least_lo <= (cap_val >= lim_lo);
            at_most_hi  <= (cap_val <= lim_hi);
            pass        <= (cap_val >= lim_lo) && (cap_val <= lim_hi) && !cap_ovf;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r4_done_pulse: assert property (@(posedge clk_ref) disable iff (!rst_n)
    done |=> !done);

  a_r4_done_after_drain: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(done) |-> $past(st == S_DRAIN));

  a_r5_start_clears: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (st == S_IDLE && start) |=> (count == '0 && !pass && !overflow && !done));

  a_r6_ovf_fails: assert property (@(posedge clk_ref) disable iff (!rst_n)
    overflow |-> (!pass && (&count)));

  a_r2_pass_needs_both: assert property (@(posedge clk_ref) disable iff (!rst_n)
    pass |-> (at_least_lo && at_most_hi));

  a_r7_gate_closed_in_drain: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (st == S_DRAIN) |-> !gate);

  a_r6_sat_hold: assert property (@(posedge sig_in) disable iff (!rst_n)
    t_ovf |-> (&t_cnt));

endmodule

// File: tb/sim_osc_freq_meter.sv
`timescale 1ns/1ps
module sim_osc_freq_meter;
  localparam int CW = 10;
  localparam int WW = 13;
  localparam int DM = 32;

  logic clk_ref = 1'b0;
  logic rst_n   = 1'b0;
  logic sig_in  = 1'b0;
  logic start   = 1'b0;
  logic [WW-1:0] win_len = '0;
  logic [CW-1:0] lim_lo = '0, lim_hi = '0;
  logic [CW-1:0] count;
  logic done, at_least_lo, at_most_hi, pass, overflow;

  int  n_chk = 0, n_err = 0;
  bit  sig_en = 1'b1;
  real sig_half = 1.25;

  osc_freq_meter #(.CW(CW), .WW(WW), .DRAIN_MAX(DM)) u0 (
    .clk_ref(clk_ref), .rst_n(rst_n), .sig_in(sig_in), .start(start),
    .win_len(win_len), .lim_lo(lim_lo), .lim_hi(lim_hi), .count(count),
    .done(done), .at_least_lo(at_least_lo), .at_most_hi(at_most_hi),
    .pass(pass), .overflow(overflow));

  always #2.5 clk_ref = ~clk_ref;

  initial forever begin
    if (sig_en) begin
      sig_in = 1'b1; #(sig_half);
      sig_in = 1'b0; #(sig_half);
    end else begin
      sig_in = 1'b0; #1;
    end
  end

  function automatic int exp_cnt(int win, real half);
    return int'($floor(win * 5.0 / (2.0 * half)));
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic measure(int win, int lo, int hi, output int lat);
    @(negedge clk_ref);
    win_len = WW'(win); lim_lo = CW'(lo); lim_hi = CW'(hi); start = 1'b1;
    @(negedge clk_ref);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 20000) begin
      @(negedge clk_ref);
      lat++;
    end
    if (!done) chk(1'b0, "R4 watchdog", lat, 0);
  endtask

  task automatic check_flags(string req, int lo, int hi);
    chk(at_least_lo == (int'(count) >= lo), {req, " R2 lo"}, at_least_lo, int'(count) >= lo);
    chk(at_most_hi == (int'(count) <= hi), {req, " R2 hi"}, at_most_hi, int'(count) <= hi);
    chk(pass == ((int'(count) >= lo) && (int'(count) <= hi) && !overflow), {req, " R2 pass"},
        pass, (int'(count) >= lo) && (int'(count) <= hi) && !overflow);
  endtask

  initial begin
    #950000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int lat, e;
    void'($urandom(1234));
    repeat (4) @(negedge clk_ref);
    rst_n = 1'b1;
    @(negedge clk_ref);
    chk(count == 0 && !done && !pass && !overflow, "R4 reset state", count, 0);

    // R1 basic
    sig_half = 1.25;
    measure(100, 150, 250, lat);
    e = exp_cnt(100, sig_half);
    chk(count >= CW'(e - 2) && count <= CW'(e + 2), "R1 count 2x", count, e);
    check_flags("R1", 150, 250);
    @(negedge clk_ref);
    chk(!done, "R4 done one cycle", done, 0);
    repeat (5) @(negedge clk_ref);
    chk(int'(count) >= e - 2 && int'(count) <= e + 2, "R4 result held", count, e);

    // R5 start clears
    @(negedge clk_ref);
    win_len = 13'd60; start = 1'b1;
    @(negedge clk_ref);
    start = 1'b0;
    chk(count == 0 && !pass && !at_least_lo && !at_most_hi, "R5 start clears", count, 0);
    lat = 1;
    while (!done && lat < 20000) begin @(negedge clk_ref); lat++; end

    // R5 start while busy ignored
    sig_half = 1.25;
    @(negedge clk_ref);
    win_len = 13'd100; lim_lo = 0; lim_hi = 1023; start = 1'b1;
    @(negedge clk_ref);
    start = 1'b0;
    repeat (10) @(negedge clk_ref);
    win_len = 13'd400; start = 1'b1;
    @(negedge clk_ref);
    start = 1'b0;
    chk(count == 0, "R5 busy start no effect", count, 0);
    lat = 12;
    while (!done && lat < 20000) begin @(negedge clk_ref); lat++; end
    e = exp_cnt(100, sig_half);
    chk(int'(count) >= e - 2 && int'(count) <= e + 2, "R5 busy start ignored", count, e);

    // R6 overflow
    sig_half = 0.5;
    measure(400, 0, 1023, lat);
    chk(overflow == 1'b1, "R6 overflow flag", overflow, 1);
    chk(count == 10'h3FF, "R6 saturated count", count, 1023);
    chk(pass == 1'b0, "R6 overflow fails", pass, 0);

    // R8 long window
    sig_half = 10.0;
    measure(4000, 990, 1010, lat);
    e = exp_cnt(4000, sig_half);
    chk(int'(count) >= e - 2 && int'(count) <= e + 2, "R8 long window", count, e);
    check_flags("R8", 990, 1010);

    // R7 dead signal, R3 exact match
    sig_en = 1'b0;
    measure(50, 0, 0, lat);
    chk(lat <= 50 + DM + 4, "R7 dead done latency", lat, 50 + DM + 4);
    chk(count == 0, "R7 dead count", count, 0);
    chk(pass == 1'b1, "R3 exact match hit", pass, 1);
    measure(50, 1, 1, lat);
    chk(pass == 1'b0 && at_most_hi, "R3 exact match miss", pass, 0);
    sig_en = 1'b1;
    sig_half = 1.25;
    measure(0, 0, 0, lat);
    chk(lat <= DM + 4, "R7 zero window latency", lat, DM + 4);
    chk(count == 0, "R7 zero window count", count, 0);

    // R1/R2 constrained random
    for (int i = 0; i < 16; i++) begin
      int win, lo, hi, ph;
      ph  = 800 + int'($urandom_range(5200));
      sig_half = ph / 1000.0;
      win = 20 + int'($urandom_range(280));
      e   = exp_cnt(win, sig_half);
      lo  = int'($urandom_range(1023));
      hi  = int'($urandom_range(1023));
      if (i % 3 == 0) begin lo = e - 5; hi = e + 5; end
      if (lo < 0) lo = 0;
      measure(win, lo, hi, lat);
      chk(int'(count) >= e - 2 && int'(count) <= e + 2, "R1 random count", count, e);
      check_flags("R1 random", lo, hi);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule